// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block produces the vertical timing of an LCD panel. It advances by one line each time the horizontal timing logic pulses `line_stb`. A frame is made of `active_lines` display lines followed by `ndp_lines` lines of vertical non-display time. When the last line of the frame is reached, the internal line counter returns to zero and a one-clock `frame_start` strobe is issued for other timing logic.

The frame pulse output depends on the panel type. For thin-film panels (`tft_mode` = 1), its leading edge falls a programmable number of lines, `fp_pos`, after the final active line, so it lies inside the non-display period. For passive panels, it marks the first line of every frame and `fp_pos` has no effect. A live status output, `vnd_status`, is high during the non-display lines.

The configuration inputs are expected to be written once at start-up. `fp_pos` must be at least 1 and no larger than `ndp_lines`, and `active_lines` must be at least 1. All outputs are registered and change only on the clock edge that samples a line strobe. The exception is `frame_start`, which lasts a single clock.

Top module: `lcd_vframe_gen`

## Requirements
- R1: The line index starts at 0 after reset and advances by one on each clock edge that samples `line_stb` = 1. After line index `active_lines + ndp_lines - 1` it returns to 0, so a frame spans `active_lines + ndp_lines` strobes.
- R2: After each accepted strobe, `vnd_status` is 1 exactly when the new line index is at least `active_lines`. Otherwise it is 0.
- R3: With `tft_mode` = 1, `frame_pulse` is 1 exactly while the line index equals `active_lines - 1 + fp_pos`. This is `fp_pos` lines after the last active line.
- R4: With `tft_mode` = 0, `frame_pulse` is 1 exactly while the line index is 0, reached through a wrap. The value of `fp_pos` has no effect on it.
- R5: Once `frame_pulse` rises, it stays high for exactly one line period, from one accepted strobe to the next.
- R6: `frame_start` is 1 for one clock, in the cycle after the strobe that returns the line index to 0. It is 0 in all other cycles.
- R7: While `rst_n` is low (asynchronous, active low), the line index is 0 and `frame_pulse`, `vnd_status` and `frame_start` are 0.
- R8: In cycles without a sampled strobe, the line index, `frame_pulse` and `vnd_status` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-clock pulse per horizontal line |
| tft_mode | input | 1 | 1 = thin-film panel, 0 = passive panel |
| active_lines | input | LINE_W | Number of display lines per frame (at least 1) |
| ndp_lines | input | NDP_W | Number of vertical non-display lines |
| fp_pos | input | NDP_W | Frame pulse offset in lines after the last active line (thin-film mode only) |
| frame_pulse | output | 1 | Frame pulse, one line long |
| vnd_status | output | 1 | High during the vertical non-display period |
| frame_start | output | 1 | One-clock strobe when the line index wraps to 0 |

## Verification
Some properties are checked on every cycle by assertions:
- outputs hold between strobes;
- `frame_start` appears only together with a zeroed line index;
- the passive frame pulse matches line 0;
- with a legal offset, the thin-film frame pulse never falls outside the non-display period;
- the reset values.

Other behaviour can only be shown by the bench's scenarios, which model the line position independently:
- the exact line on which the pulse lands for the offsets 1, mid-range and equal to the non-display length;
- that `fp_pos` is ignored in passive mode even when it changes mid-frame;
- the exact length of the frame across several wraps.

// File: rtl/lcd_vframe_gen.sv
module lcd_vframe_gen #(
  parameter int LINE_W = 10,
  parameter int NDP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              tft_mode,
  input  logic [LINE_W-1:0] active_lines,
  input  logic [NDP_W-1:0]  ndp_lines,
  input  logic [NDP_W-1:0]  fp_pos,
  output logic              frame_pulse,
  output logic              vnd_status,
  output logic              frame_start
);
  localparam int CNT_W = (LINE_W > NDP_W ? LINE_W : NDP_W) + 1;

  logic [CNT_W-1:0] lcnt, total, nxt, fp_line;
  logic             wrap;

  assign total   = CNT_W'(active_lines) + CNT_W'(ndp_lines);
  assign wrap    = (lcnt + CNT_W'(1)) >= total;
  assign nxt     = wrap ? '0 : lcnt + CNT_W'(1);
  assign fp_line = CNT_W'(active_lines) - CNT_W'(1) + CNT_W'(fp_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt        <= '0;
      frame_pulse <= 1'b0;
      vnd_status  <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= line_stb && wrap;
      if (line_stb) begin
        lcnt        <= nxt;
        vnd_status  <= nxt >= CNT_W'(active_lines);
        frame_pulse <= tft_mode ? (nxt == fp_line) : (nxt == '0);
      end
    end
  end

  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> $stable(lcnt) && $stable(frame_pulse) && $stable(vnd_status)); // R8

  AST_START_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (lcnt == '0) && $past(line_stb)); // R6

  AST_PASSIVE_PULSE_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && !tft_mode |=> frame_pulse == (lcnt == '0)); // R4

  AST_TFT_PULSE_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    line_stb && tft_mode && fp_pos != '0 && fp_pos <= ndp_lines && active_lines != '0
    |=> !frame_pulse || vnd_status); // R3

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lcnt == '0 && !frame_pulse && !vnd_status && !frame_start); // R7
endmodule

// File: tb/lcd_vframe_gen_tb.sv
`timescale 1ns/1ps
module lcd_vframe_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, line_stb = 1'b0, tft_mode = 1'b1;
  logic [9:0] active_lines = 10'd5;
  logic [5:0] ndp_lines = 6'd4, fp_pos = 6'd2;
  logic frame_pulse, vnd_status, frame_start;

  always #10 clk = ~clk;

  lcd_vframe_gen dut_i (.clk(clk), .rst_n(rst_n), .line_stb(line_stb), .tft_mode(tft_mode),
    .active_lines(active_lines), .ndp_lines(ndp_lines), .fp_pos(fp_pos),
    .frame_pulse(frame_pulse), .vnd_status(vnd_status), .frame_start(frame_start));

  typedef struct { logic fp; logic vnd; logic fs; logic tft; } exp_t;
  exp_t q[$];
  int runs = 0, fails = 0, bl = 0;
  logic pending = 1'b0, last_fp = 1'b0, last_vnd = 1'b0, done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: model next line from the requirements, push expectation, pulse strobe
  task automatic line(int gap);
    exp_t e;
    int tot = int'(active_lines) + int'(ndp_lines);
    @(negedge clk);
    e.fs = (bl + 1 >= tot);                                  // R1 wrap
    bl = e.fs ? 0 : bl + 1;
    e.vnd = (bl >= int'(active_lines));                      // R2
    e.fp  = tft_mode ? (bl == int'(active_lines) - 1 + int'(fp_pos)) : (bl == 0);
    e.tft = tft_mode;
    q.push_back(e);
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 frame_pulse", frame_pulse, 0);
    chk("R7 vnd_status", vnd_status, 0);
    chk("R7 frame_start", frame_start, 0);
    rst_n = 1'b1;
    bl = 0; last_fp = 1'b0; last_vnd = 1'b0;
  endtask

  always @(posedge clk) if (rst_n && line_stb) pending <= 1'b1;

  // monitor: compare results against the queue
  always @(negedge clk) begin
    if (pending) begin
      exp_t e;
      pending <= 1'b0;
      e = q.pop_front();
      chk(e.tft ? "R3/R5 frame_pulse" : "R4/R5 frame_pulse", frame_pulse, e.fp);
      chk("R2 vnd_status", vnd_status, e.vnd);
      chk("R1/R6 frame_start", frame_start, e.fs);
      last_fp <= frame_pulse; last_vnd <= vnd_status;
    end else if (rst_n && !line_stb) begin
      chk("R6 frame_start idle", frame_start, 0);
      chk("R8 frame_pulse hold", frame_pulse, last_fp);
      chk("R8 vnd_status hold", vnd_status, last_vnd);
    end
  end

  initial begin
    do_reset();
    // thin-film, mid offset, varied gaps, two frames plus
    for (int i = 0; i < 20; i++) line(i % 3);
    // offset at lower bound
    fp_pos = 6'd1; do_reset();
    for (int i = 0; i < 18; i++) line(1);
    // offset equal to the non-display length
    fp_pos = 6'd4; do_reset();
    for (int i = 0; i < 18; i++) line(0);
    // passive, offset ignored and changed mid-frame
    tft_mode = 1'b0; fp_pos = 6'd3; active_lines = 10'd3; ndp_lines = 6'd2; do_reset();
    for (int i = 0; i < 12; i++) begin
      if (i == 4) fp_pos = 6'd1;
      line(2);
    end
    // single-line frames in passive mode
    active_lines = 10'd1; ndp_lines = 6'd0; do_reset();
    for (int i = 0; i < 4; i++) line(0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      runs++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule